// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This block reorders the bytes of one 32-bit operand for an integer execution pipeline. A 2-bit select chooses one of three permutations: reversing the four bytes of the word, swapping the two bytes inside each halfword, or exchanging the two halfwords. A fourth code passes the operand through unchanged. The block also produces four status flags for the result: zero, sign, carry and overflow. The carry flag is a per-operation detector for zero bytes or zero halfwords, and software uses it to find string terminators after a swap.

The unit is one stage of logic. A parameter chooses between a purely combinational path and one output register stage. With the register stage, the result, the flags and a valid strobe appear one clock after the input is presented. The register stage loads only on cycles where the input is marked valid, and it holds its previous contents on all other cycles. There is no state machine. The only state is the optional output register, and it has two conditions: idle (holding) and load.

Top module: `bswap_unit`

## Requirements
- R1: With op_sel = 2'b00, result byte k (bits [8k+7:8k]) equals source byte 3-k, for k from 0 to 3.
- R2: With op_sel = 2'b01, result bits [31:24] equal source bits [23:16], result bits [23:16] equal source bits [31:24], result bits [15:8] equal source bits [7:0], and result bits [7:0] equal source bits [15:8].
- R3: With op_sel = 2'b10, result bits [31:16] equal source bits [15:0], and result bits [15:0] equal source bits [31:16].
- R4: With op_sel = 2'b11, the result equals the source, and all four flags are 0.
- R5: For op_sel 00, 01 and 10, flag_z is 1 exactly when the 32-bit result is zero.
- R6: For op_sel 00, 01 and 10, flag_s equals result bit 31.
- R7: flag_ov is 0 for every operation.
- R8: With op_sel = 2'b00, flag_cy is 1 exactly when at least one of the four result bytes is 0x00.
- R9: With op_sel = 2'b10, flag_cy is 1 exactly when result bits [31:16] are zero or result bits [15:0] are zero.
- R10: With op_sel = 2'b01, flag_cy is 1 exactly when result bits [7:0] are zero.
- R11: With REGISTERED = 1, out_valid is in_valid delayed by one clock. The result and flags for an input accepted at a rising edge are visible after that edge. While rst_n is low, out_valid, the result and all flags are 0.
- R12: With REGISTERED = 1, an edge at which in_valid is 0 leaves the result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the operand and select as valid this cycle |
| op_sel | input | 2 | Operation: 00 reverse bytes, 01 swap within halfwords, 10 exchange halfwords, 11 pass through |
| src | input | 32 | Source operand |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Reordered word |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 31 |
| flag_cy | output | 1 | Per-operation zero-byte or zero-halfword detector |
| flag_ov | output | 1 | Always 0 |

## Verification
The only internal state is the output register. If it loads on a wrong edge, it shows up at the ports as a changed result during an idle cycle. If it fails to load, it shows up as a stale result one cycle after a valid input. Either error is visible in the first sample after the faulty edge. A wrong byte lane or a wrong carry detector is combinational, so it appears in the same registered sample as the operand that triggers it. For this reason the stimulus includes operands with exactly one zero byte in each lane, operands with exactly one zero halfword, and operands whose only zero byte lands in the low result byte for a single operation.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

    typedef enum logic [1:0] {
        OP_REV  = 2'b00,
        OP_PAIR = 2'b01,
        OP_HALF = 2'b10,
        OP_PASS = 2'b11
    } swap_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } swap_flags_t;

endpackage

// File: rtl/bswap_permute.sv
module bswap_permute
    import bswap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  swap_op_e            op,
    input  logic [DATA_W-1:0]   src,
    output logic [DATA_W-1:0]   res
);
    localparam int LANE_W = 8;
    localparam int NB     = DATA_W / LANE_W;
    localparam int HALF_B = NB / 2;

    logic [DATA_W-1:0] rev_w;
    logic [DATA_W-1:0] pair_w;
    logic [DATA_W-1:0] half_w;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign rev_w [g*LANE_W +: LANE_W] = src[(NB-1-g)*LANE_W +: LANE_W];
        assign pair_w[g*LANE_W +: LANE_W] = src[(g^1)*LANE_W +: LANE_W];
        assign half_w[g*LANE_W +: LANE_W] = src[((g+HALF_B)%NB)*LANE_W +: LANE_W];
    end

    always_comb begin
        unique case (op)
            OP_REV:  res = rev_w;
            OP_PAIR: res = pair_w;
            OP_HALF: res = half_w;
            default: res = src;
        endcase
    end

endmodule

// File: rtl/bswap_flags.sv
module bswap_flags
    import bswap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  swap_op_e            op,
    input  logic [DATA_W-1:0]   res,
    output swap_flags_t         flg
);
    localparam int LANE_W = 8;
    localparam int NB     = DATA_W / LANE_W;
    localparam int HALF_B = NB / 2;

    logic [NB-1:0] byte_zero;

    for (genvar g = 0; g < NB; g++) begin : g_bz
        assign byte_zero[g] = (res[g*LANE_W +: LANE_W] == '0);
    end

    logic lo_half_zero;
    logic hi_half_zero;
    assign lo_half_zero = &byte_zero[HALF_B-1:0];
    assign hi_half_zero = &byte_zero[NB-1:HALF_B];

    always_comb begin
        flg = '0;
        unique case (op)
            OP_REV: begin
                flg.z  = &byte_zero;
                flg.s  = res[DATA_W-1];
                flg.cy = |byte_zero;
            end
            OP_PAIR: begin
                flg.z  = &byte_zero;
                flg.s  = res[DATA_W-1];
                flg.cy = byte_zero[0];
            end
            OP_HALF: begin
                flg.z  = &byte_zero;
                flg.s  = res[DATA_W-1];
                flg.cy = lo_half_zero | hi_half_zero;
            end
            default: flg = '0;
        endcase
    end

endmodule

// File: rtl/bswap_outstage.sv
module bswap_outstage
    import bswap_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   res_d,
    input  swap_flags_t         flg_d,
    output logic                out_valid,
    output logic [DATA_W-1:0]   res_q,
    output swap_flags_t         flg_q
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                res_q     <= '0;
                flg_q     <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    res_q <= res_d;
                    flg_q <= flg_d;
                end
            end
        end

        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid)); // R11

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(in_valid) |-> ($stable(res_q) && $stable(flg_q))); // R12
    end else begin : g_comb
        assign out_valid = in_valid;
        assign res_q     = res_d;
        assign flg_q     = flg_d;
    end

endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
    import bswap_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          op_sel,
    input  logic [DATA_W-1:0]   src,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                flag_z,
    output logic                flag_s,
    output logic                flag_cy,
    output logic                flag_ov
);
    localparam int HW = DATA_W / 2;

    swap_op_e          op_e;
    logic [DATA_W-1:0] perm_res;
    swap_flags_t       nxt_flg;
    swap_flags_t       out_flg;

    assign op_e = swap_op_e'(op_sel);

    bswap_permute #(.DATA_W(DATA_W)) u_perm (
        .op  (op_e),
        .src (src),
        .res (perm_res)
    );

    bswap_flags #(.DATA_W(DATA_W)) u_flags (
        .op  (op_e),
        .res (perm_res),
        .flg (nxt_flg)
    );

    bswap_outstage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .res_d     (perm_res),
        .flg_d     (nxt_flg),
        .out_valid (out_valid),
        .res_q     (result),
        .flg_q     (out_flg)
    );

    assign flag_z  = out_flg.z;
    assign flag_s  = out_flg.s;
    assign flag_cy = out_flg.cy;
    assign flag_ov = out_flg.ov;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_ov); // R7

    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e != OP_PASS) |-> (nxt_flg.z == (perm_res == '0))); // R5

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e != OP_PASS) |-> (nxt_flg.s == perm_res[DATA_W-1])); // R6

    AST_PASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_PASS) |-> (nxt_flg == '0 && perm_res == src)); // R4

    AST_HALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_HALF) |->
        (nxt_flg.cy == ((perm_res[DATA_W-1:HW] == '0) || (perm_res[HW-1:0] == '0)))); // R9

    AST_PAIR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_PAIR) |-> (nxt_flg.cy == (src[15:8] == 8'h00))); // R10

endmodule

// File: tb/tb_bswap_unit.sv
module tb_bswap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] src = 32'h0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_z, flag_s, flag_cy, flag_ov;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state: what the outputs show after the latest edge
    logic [31:0] m_res = 32'h0;
    logic        m_z = 0, m_s = 0, m_cy = 0, m_ov = 0, m_v = 0;
    logic [1:0]  m_op = 2'b00;
    bit          m_held = 0;

    always #2 clk = ~clk;

    bswap_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .src(src),
        .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] op, input logic [31:0] d);
        logic [7:0] b [4];
        logic [7:0] r [4];
        int zeros;
        for (int i = 0; i < 4; i++) b[i] = d[8*i +: 8];
        case (op)
            2'b00: for (int i = 0; i < 4; i++) r[i] = b[3-i];
            2'b01: begin r[0] = b[1]; r[1] = b[0]; r[2] = b[3]; r[3] = b[2]; end
            2'b10: begin r[0] = b[2]; r[1] = b[3]; r[2] = b[0]; r[3] = b[1]; end
            default: for (int i = 0; i < 4; i++) r[i] = b[i];
        endcase
        m_res = {r[3], r[2], r[1], r[0]};
        zeros = 0;
        for (int i = 0; i < 4; i++) if (r[i] == 8'h00) zeros++;
        m_ov = 1'b0;
        if (op == 2'b11) begin
            m_z = 0; m_s = 0; m_cy = 0;
        end else begin
            m_z = (zeros == 4);
            m_s = r[3][7];
            if (op == 2'b00)      m_cy = (zeros > 0);
            else if (op == 2'b01) m_cy = (r[0] == 8'h00);
            else                  m_cy = ((r[0] == 0 && r[1] == 0) || (r[2] == 0 && r[3] == 0));
        end
        m_op = op;
    endtask

    task automatic compare();
        string rt, ct;
        case (m_op)
            2'b00: begin rt = "R1"; ct = "R8"; end
            2'b01: begin rt = "R2"; ct = "R10"; end
            2'b10: begin rt = "R3"; ct = "R9"; end
            default: begin rt = "R4"; ct = "R4"; end
        endcase
        if (m_held) begin rt = "R12"; ct = "R12"; end
        chk("R11", "out_valid", {31'b0, out_valid}, {31'b0, m_v});
        chk(rt, "result", result, m_res);
        chk(ct, "flag_cy", {31'b0, flag_cy}, {31'b0, m_cy});
        chk(m_op == 2'b11 ? "R4" : "R5", "flag_z", {31'b0, flag_z}, {31'b0, m_z});
        chk(m_op == 2'b11 ? "R4" : "R6", "flag_s", {31'b0, flag_s}, {31'b0, m_s});
        chk("R7", "flag_ov", {31'b0, flag_ov}, {31'b0, m_ov});
    endtask

    // drive at a falling edge, model the rising edge, compare at next falling edge
    task automatic cyc(input logic v, input logic [1:0] op, input logic [31:0] d);
        in_valid = v; op_sel = op; src = d;
        @(posedge clk);
        m_v = v;
        m_held = !v;
        if (v) model(op, d);
        @(negedge clk);
        compare();
    endtask

    initial begin
        logic [31:0] lf;
        @(negedge clk);
        @(negedge clk);
        // reset state: R11
        chk("R11", "reset out_valid", {31'b0, out_valid}, 32'h0);
        chk("R11", "reset result", result, 32'h0);
        chk("R11", "reset flags", {28'b0, flag_z, flag_s, flag_cy, flag_ov}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        for (int op = 0; op < 4; op++) begin
            cyc(1, op[1:0], 32'h12345678);
            cyc(1, op[1:0], 32'h00000000);
            cyc(1, op[1:0], 32'h80000000);
            cyc(1, op[1:0], 32'h00FF00FF);
            cyc(1, op[1:0], 32'h0000ABCD);
            cyc(1, op[1:0], 32'hABCD0000);
            cyc(1, op[1:0], 32'h11002233);
            cyc(1, op[1:0], 32'h11223300);
            cyc(1, op[1:0], 32'h00112233);
            cyc(1, op[1:0], 32'h11220033);
            cyc(1, op[1:0], 32'hFFFFFFFF);
            cyc(0, op[1:0], 32'h00000000);   // R12 hold
            cyc(0, 2'b11, 32'hDEADBEEF);     // R12 hold
        end

        lf = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[4:3] == 2'b01) cyc(1, lf[1:0], lf & 32'hFF00FFFF);
            else                  cyc(lf[7] | lf[9], lf[1:0], lf);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule